// File: doc/BRIEF.md
# Serial Link Initialization Controller

This block is the control state machine of a point-to-point data-strobe serial link. It sits between a character-level receiver and transmitter, both outside the block. It brings the link up through a timed handshake. After reset it holds the receiver off for a settling period, then listens with the line silent. When a start request arrives, or when autostart is set and a NULL has been seen, it has the transmitter send NULLs. Once a NULL comes back it moves on to FCT exchange. The first FCT received puts the link into the running state.

While the link runs, the block keeps two credit counts. The first is transmit credit: each received FCT adds eight characters, and the user's transmit-ready is withheld when this count reaches zero. The second is receive credit that has been granted but not yet used: a new FCT is requested only when the receive buffer reports room for eight characters beyond what is already granted. A fault in the running state raises a one-cycle error flag and drops the link back to reset. A time-out or an unexpected character during start-up resets the link with no flag. All timers count system clocks and are derived from the clock-frequency parameter.

Top module: `link_init_ctrl`

## Requirements
- R1: While reset is low and for the 1280 clocks after its release (6.4 us at 200 MHz), `rx_enable` is 0, all state and error flags are 0 and `tx_mode` is 0 (silent). `rx_enable` rises on the 1280th clock after release.
- R2: A start request takes effect only after a further wait of 2560 clocks (12.8 us) with the receiver enabled. With `link_start` held from reset, `started` is 0 after 3840 clocks and 1 after 3841 clocks.
- R3: In the started state `tx_mode` is 1 (send NULLs). When `link_auto` is set without a start request, the block leaves the ready state only after a NULL has been received.
- R4: If no NULL is received within 2560 clocks of entering the started state, the block returns to reset (`rx_enable` 0) and raises no error flag.
- R5: A received NULL moves the block from started to connecting, one clock after the NULL is registered, and `tx_mode` becomes 2 (send FCTs and NULLs).
- R6: An FCT received while connecting moves the block to running, with 8 characters of transmit credit (`tx_ready` 1) and `tx_mode` 3. Without an FCT, connecting ends silently in reset after 2560 clocks.
- R7: In the started or connecting state, a received data character, end-of-packet or time code resets the link with no error flag.
- R8: In the running state, a disconnect, parity or escape error report raises the matching error flag for exactly one clock, and `running` falls in the same cycle.
- R9: Each accepted `tx_write` uses one credit. After 8 writes on one FCT, `tx_ready` is 0, and a further FCT restores it.
- R10: Transmit credit may reach 56. An FCT that would raise it above 56 sets `err_cred` and resets the link.
- R11: `fct_req` is 1 only while connecting or running and when `rx_room` is at least the outstanding receive credit plus 8. Each `fct_ack` adds 8 to the outstanding credit.
- R12: Each received character uses one outstanding receive credit. A character that arrives while running with zero outstanding credit sets `err_cred` and resets the link.
- R13: `link_dis` takes the link out of running one clock after it is sampled, with no error flag, and it blocks a start from the ready state.
- R14: At most one of `started`, `connecting` and `running` is 1 at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| link_start | input | 1 | Request to start the link |
| link_auto | input | 1 | Start automatically on the first received NULL |
| link_dis | input | 1 | Force the link down |
| rx_room | input | ROOM_W | Free characters in the receive buffer |
| rx_null | input | 1 | Receiver decoded a NULL |
| rx_fct | input | 1 | Receiver decoded an FCT |
| rx_char | input | 1 | Receiver decoded a data character, EOP or EEP |
| rx_time | input | 1 | Receiver decoded a time code |
| rx_par_err | input | 1 | Receiver parity error |
| rx_esc_err | input | 1 | Receiver escape-sequence error |
| rx_disc | input | 1 | Receiver disconnect detected |
| tx_write | input | 1 | User writes one character (taken when `tx_ready`) |
| fct_ack | input | 1 | Transmitter has sent the requested FCT |
| rx_enable | output | 1 | Enable for the receiver |
| tx_mode | output | 2 | 0 silent, 1 NULLs, 2 FCTs and NULLs, 3 all traffic |
| fct_req | output | 1 | Request to send one FCT |
| tx_ready | output | 1 | Transmit credit available while running |
| started | output | 1 | In the started state |
| connecting | output | 1 | In the connecting state |
| running | output | 1 | In the running state |
| err_disc | output | 1 | One-cycle disconnect error |
| err_par | output | 1 | One-cycle parity error |
| err_esc | output | 1 | One-cycle escape error |
| err_cred | output | 1 | One-cycle credit error |

## Verification
The hardest conditions to reach are the two credit faults. Each needs a running link with a particular credit balance. The transmit side needs eight FCT grants on top of an exhausted count. The receive side needs a character to arrive exactly when the acknowledged FCTs have all been used. The stimulus gets there by walking the handshake first: reset wait, start, NULL, then FCT. It then steps the balance one event at a time, checking that nothing fires at the boundary value before pushing one event past it. The time-outs are hit with cycle counts derived from the 200 MHz clock, checked one cycle before and one cycle at expiry.

// File: rtl/lnk_pkg.sv
// Package: shared state and transmit-mode encodings for the link controller.
package lnk_pkg;
    typedef enum logic [2:0] {
        ST_ERR_RESET,
        ST_ERR_WAIT,
        ST_READY,
        ST_STARTED,
        ST_CONNECTING,
        ST_RUN
    } lnk_state_t;

    typedef enum logic [1:0] {
        TXM_SILENT = 2'd0,
        TXM_NULLS  = 2'd1,
        TXM_FCT    = 2'd2,
        TXM_ALL    = 2'd3
    } tx_mode_t;
endpackage

// File: rtl/lnk_timer.sv
// lnk_timer: counts the clocks spent in the current state.
// done is high during the last cycle of a window of LIMIT_A clocks
// (sel_b low) or LIMIT_B clocks (sel_b high), counted from the edge
// that asserted restart. Assumes both limits are at least 2.
module lnk_timer #(
    parameter int LIMIT_A = 1280,
    parameter int LIMIT_B = 2560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic sel_b,
    output logic done
);
    localparam int MAXL = (LIMIT_A > LIMIT_B) ? LIMIT_A : LIMIT_B;
    localparam int TW   = $clog2(MAXL + 1);
    localparam logic [TW-1:0] LAST_A = TW'(LIMIT_A - 1);
    localparam logic [TW-1:0] LAST_B = TW'(LIMIT_B - 1);
    localparam logic [TW-1:0] TOP    = TW'(MAXL);

    logic [TW-1:0] cnt_q;

    // Count up from zero after each restart, saturating at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt_q <= '0;
        else if (cnt_q != TOP)
            cnt_q <= cnt_q + 1'b1;
    end

    // Flag the last cycle of the selected window.
    always_comb done = sel_b ? (cnt_q == LAST_B) : (cnt_q == LAST_A);
endmodule

// File: rtl/lnk_tx_credit.sv
// lnk_tx_credit: transmit credit granted by the far end.
// Each grant adds STEP characters and each spend removes one. A grant that
// would exceed CAP is refused and reported on over. The count clears
// whenever enable is low. Assumes spend only when has_credit is high.
module lnk_tx_credit #(
    parameter int STEP = 8,
    parameter int CAP  = 56
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic grant,
    input  logic spend,
    output logic has_credit,
    output logic over
);
    localparam int CW = $clog2(CAP + STEP + 1);
    localparam logic [CW-1:0] STEP_V = CW'(STEP);
    localparam logic [CW-1:0] CAP_V  = CW'(CAP);

    logic [CW-1:0] cred_q;
    logic [CW-1:0] cred_d;

    // Detect an over-cap grant and form the next count.
    always_comb begin
        over   = grant && ((cred_q + STEP_V) > CAP_V);
        cred_d = cred_q;
        if (grant && !over)
            cred_d = cred_d + STEP_V;
        if (spend && cred_q != '0)
            cred_d = cred_d - 1'b1;
    end

    // Hold the count; clear it while the link is not exchanging FCTs.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            cred_q <= '0;
        else
            cred_q <= cred_d;
    end

    always_comb has_credit = (cred_q != '0);
endmodule

// File: rtl/lnk_rx_credit.sv
// lnk_rx_credit: receive credit granted to the far end and not yet used.
// Requests an FCT while the buffer room covers the outstanding credit
// plus STEP. Each acknowledged FCT adds STEP, and each received character
// removes one. A character with no credit left is reported on under.
module lnk_rx_credit #(
    parameter int STEP   = 8,
    parameter int CAP    = 56,
    parameter int ROOM_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [ROOM_W-1:0] room,
    input  logic              ack,
    input  logic              rx_char,
    output logic              fct_req,
    output logic              under
);
    localparam int CW  = $clog2(CAP + STEP + 1);
    localparam int MW  = ((CW > ROOM_W) ? CW : ROOM_W) + 1;
    localparam logic [CW-1:0] STEP_V = CW'(STEP);

    logic [CW-1:0] cred_q;
    logic [CW-1:0] cred_d;
    logic [MW-1:0] need;
    logic [MW-1:0] have;

    // Compare room with outstanding credit plus one FCT worth.
    always_comb begin
        need    = MW'(cred_q) + MW'(STEP);
        have    = MW'(room);
        fct_req = enable && (have >= need);
        under   = rx_char && (cred_q == '0);
        cred_d  = cred_q;
        if (ack && fct_req)
            cred_d = cred_d + STEP_V;
        if (rx_char && !under)
            cred_d = cred_d - 1'b1;
    end

    // Hold the outstanding credit; clear it while the link is down.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable)
            cred_q <= '0;
        else
            cred_q <= cred_d;
    end
endmodule

// File: rtl/link_init_ctrl.sv
// link_init_ctrl: start-up and supervision state machine of a data-strobe
// serial link. It sequences reset wait, ready, started (NULLs), connecting
// (FCTs) and running, and keeps both credit counts. Faults in the running
// state raise one-cycle error flags. Start-up faults reset silently.
// Assumes the receiver event inputs are single-cycle pulses in this clock
// domain and that fct_ack is only given while fct_req is high.
module link_init_ctrl #(
    parameter int CLK_KHZ   = 200000,
    parameter int FCT_CHARS = 8,
    parameter int CAP_FCTS  = 7,
    parameter int ROOM_W    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              link_start,
    input  logic              link_auto,
    input  logic              link_dis,
    input  logic [ROOM_W-1:0] rx_room,
    input  logic              rx_null,
    input  logic              rx_fct,
    input  logic              rx_char,
    input  logic              rx_time,
    input  logic              rx_par_err,
    input  logic              rx_esc_err,
    input  logic              rx_disc,
    input  logic              tx_write,
    input  logic              fct_ack,
    output logic              rx_enable,
    output logic [1:0]        tx_mode,
    output logic              fct_req,
    output logic              tx_ready,
    output logic              started,
    output logic              connecting,
    output logic              running,
    output logic              err_disc,
    output logic              err_par,
    output logic              err_esc,
    output logic              err_cred
);
    import lnk_pkg::*;

    localparam int RST_CYC  = (CLK_KHZ * 64) / 10000;
    localparam int WAIT_CYC = 2 * RST_CYC;
    localparam int CRED_CAP = FCT_CHARS * CAP_FCTS;

    lnk_state_t state_q, state_d;
    logic       null_seen_q;
    logic       t_done;
    logic       link_up;
    logic       tx_has, tx_over, rx_under;
    logic       bad_early, run_fault, in_run;

    always_comb begin
        in_run    = (state_q == ST_RUN);
        link_up   = (state_q == ST_CONNECTING) || in_run;
        bad_early = rx_char || rx_time || rx_par_err || rx_esc_err || rx_disc;
        run_fault = rx_disc || rx_par_err || rx_esc_err || tx_over || rx_under;
    end

    lnk_timer #(
        .LIMIT_A (RST_CYC),
        .LIMIT_B (WAIT_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_d != state_q),
        .sel_b   (state_q != ST_ERR_RESET),
        .done    (t_done)
    );

    lnk_tx_credit #(
        .STEP (FCT_CHARS),
        .CAP  (CRED_CAP)
    ) u_txcred (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (link_up),
        .grant      (rx_fct && link_up),
        .spend      (tx_write && tx_ready),
        .has_credit (tx_has),
        .over       (tx_over)
    );

    lnk_rx_credit #(
        .STEP   (FCT_CHARS),
        .CAP    (CRED_CAP),
        .ROOM_W (ROOM_W)
    ) u_rxcred (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (link_up),
        .room    (rx_room),
        .ack     (fct_ack),
        .rx_char (rx_char && in_run),
        .fct_req (fct_req),
        .under   (rx_under)
    );

    // Remember a received NULL from the end of the reset wait onwards.
    always_ff @(posedge clk) begin
        if (!rst_n || state_q == ST_ERR_RESET)
            null_seen_q <= 1'b0;
        else if (rx_null)
            null_seen_q <= 1'b1;
    end

    // Choose the next link state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ERR_RESET:  if (t_done) state_d = ST_ERR_WAIT;
            ST_ERR_WAIT:   if (bad_early) state_d = ST_ERR_RESET;
                           else if (t_done) state_d = ST_READY;
            ST_READY:      if (bad_early) state_d = ST_ERR_RESET;
                           else if (!link_dis && (link_start || (link_auto && null_seen_q)))
                               state_d = ST_STARTED;
            ST_STARTED:    if (bad_early || link_dis) state_d = ST_ERR_RESET;
                           else if (null_seen_q) state_d = ST_CONNECTING;
                           else if (t_done) state_d = ST_ERR_RESET;
            ST_CONNECTING: if (bad_early || link_dis) state_d = ST_ERR_RESET;
                           else if (rx_fct) state_d = ST_RUN;
                           else if (t_done) state_d = ST_ERR_RESET;
            ST_RUN:        if (link_dis || run_fault) state_d = ST_ERR_RESET;
            default:       state_d = ST_ERR_RESET;
        endcase
    end

    // Register the link state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_ERR_RESET;
        else
            state_q <= state_d;
    end

    // Register one-cycle error flags for faults seen while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_disc <= 1'b0;
            err_par  <= 1'b0;
            err_esc  <= 1'b0;
            err_cred <= 1'b0;
        end else begin
            err_disc <= in_run && rx_disc;
            err_par  <= in_run && rx_par_err;
            err_esc  <= in_run && rx_esc_err;
            err_cred <= in_run && (tx_over || rx_under);
        end
    end

    // Decode the state register into status and transmitter commands.
    always_comb begin
        rx_enable  = (state_q != ST_ERR_RESET);
        started    = (state_q == ST_STARTED);
        connecting = (state_q == ST_CONNECTING);
        running    = in_run;
        tx_ready   = in_run && tx_has;
        unique case (state_q)
            ST_STARTED:    tx_mode = TXM_NULLS;
            ST_CONNECTING: tx_mode = TXM_FCT;
            ST_RUN:        tx_mode = TXM_ALL;
            default:       tx_mode = TXM_SILENT;
        endcase
    end
endmodule

// File: rtl/link_init_ctrl_chk.sv
// link_init_ctrl_chk: property checker bound to link_init_ctrl.
// It observes ports only and holds no state of its own.
module link_init_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       link_dis,
    input logic       rx_enable,
    input logic [1:0] tx_mode,
    input logic       fct_req,
    input logic       tx_ready,
    input logic       started,
    input logic       connecting,
    input logic       running,
    input logic       err_disc,
    input logic       err_par,
    input logic       err_esc,
    input logic       err_cred
);
    logic err_any;
    always_comb err_any = err_disc || err_par || err_esc || err_cred;

    a_r14_one_state: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({started, connecting, running}));

    a_r1_silent_when_rx_off: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |-> (tx_mode == 2'd0 && !started && !connecting && !running));

    a_r8_err_from_run: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |-> ($past(running) && !running));

    a_r8_err_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        err_any |=> !err_any);

    a_r9_ready_only_running: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> running);

    a_r11_req_only_linked: assert property (@(posedge clk) disable iff (!rst_n)
        fct_req |-> (connecting || running));

    a_r13_disable_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (running && link_dis) |=> (!running && !err_any));
endmodule

bind link_init_ctrl link_init_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .link_dis   (link_dis),
    .rx_enable  (rx_enable),
    .tx_mode    (tx_mode),
    .fct_req    (fct_req),
    .tx_ready   (tx_ready),
    .started    (started),
    .connecting (connecting),
    .running    (running),
    .err_disc   (err_disc),
    .err_par    (err_par),
    .err_esc    (err_esc),
    .err_cred   (err_cred)
);

// File: tb/link_init_ctrl_test.sv
// link_init_ctrl_test: directed scenarios, one task each, self-checking.
module link_init_ctrl_test;
    localparam int RST_CYC = 1280;   // 6.4 us at 200 MHz
    localparam int TO_CYC  = 2560;   // 12.8 us at 200 MHz
    localparam int EV_NULL = 0, EV_FCT = 1, EV_CHAR = 2, EV_TIME = 3,
                   EV_PAR = 4, EV_ESC = 5, EV_DISC = 6, EV_ACK = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_start = 0, link_auto = 0, link_dis = 0;
    logic [5:0] rx_room = '0;
    logic       rx_null = 0, rx_fct = 0, rx_char = 0, rx_time = 0;
    logic       rx_par_err = 0, rx_esc_err = 0, rx_disc = 0;
    logic       tx_write = 0, fct_ack = 0;
    logic       rx_enable, fct_req, tx_ready, started, connecting, running;
    logic       err_disc, err_par, err_esc, err_cred;
    logic [1:0] tx_mode;

    int checks = 0;
    int errors = 0;
    int onehot_bad = 0;
    bit err_seen = 0;
    bit done = 0;

    link_init_ctrl uut (
        .clk(clk), .rst_n(rst_n), .link_start(link_start), .link_auto(link_auto),
        .link_dis(link_dis), .rx_room(rx_room), .rx_null(rx_null), .rx_fct(rx_fct),
        .rx_char(rx_char), .rx_time(rx_time), .rx_par_err(rx_par_err),
        .rx_esc_err(rx_esc_err), .rx_disc(rx_disc), .tx_write(tx_write),
        .fct_ack(fct_ack), .rx_enable(rx_enable), .tx_mode(tx_mode),
        .fct_req(fct_req), .tx_ready(tx_ready), .started(started),
        .connecting(connecting), .running(running), .err_disc(err_disc),
        .err_par(err_par), .err_esc(err_esc), .err_cred(err_cred)
    );

    always #2.5 clk = ~clk;

    // Watch error flags and state-flag exclusivity at every falling edge.
    always @(negedge clk) begin
        if (err_disc | err_par | err_esc | err_cred) err_seen = 1;
        if ((int'(started) + int'(connecting) + int'(running)) > 1) onehot_bad++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_ev(input int ev, input logic v);
        case (ev)
            EV_NULL: rx_null    = v;
            EV_FCT:  rx_fct     = v;
            EV_CHAR: rx_char    = v;
            EV_TIME: rx_time    = v;
            EV_PAR:  rx_par_err = v;
            EV_ESC:  rx_esc_err = v;
            EV_DISC: rx_disc    = v;
            default: fct_ack    = v;
        endcase
    endtask

    task automatic pulse(input int ev);
        set_ev(ev, 1'b1);
        tick(1);
        set_ev(ev, 1'b0);
    endtask

    task automatic go_ready();
        rst_n = 0; link_start = 0; link_auto = 0; link_dis = 0;
        rx_room = '0; tx_write = 0;
        tick(2);
        rst_n = 1;
        tick(RST_CYC + TO_CYC + 1);
        err_seen = 0;
    endtask

    task automatic connect();
        go_ready();
        link_start = 1;
        tick(1);
        link_start = 0;
        pulse(EV_NULL);
        tick(1);
    endtask

    task automatic to_run();
        connect();
        pulse(EV_FCT);
    endtask

    task automatic t_reset_timing();
        rst_n = 0; link_start = 1;
        tick(2);
        chk(!rx_enable && !started && !connecting && !running && tx_mode == 0 &&
            !err_disc && !err_par && !err_esc && !err_cred, "R1 reset state", rx_enable, 0);
        rst_n = 1;
        tick(RST_CYC - 1);
        chk(rx_enable == 0, "R1 rx off before 6.4us", rx_enable, 0);
        tick(1);
        chk(rx_enable == 1, "R1 rx on at 6.4us", rx_enable, 1);
        tick(TO_CYC);
        chk(started == 0, "R2 no start before wait ends", started, 0);
        tick(1);
        chk(started == 1, "R2 start after wait", started, 1);
        chk(tx_mode == 2'd1, "R3 NULLs in started", tx_mode, 1);
        link_start = 0;
    endtask

    task automatic t_autostart();
        go_ready();
        link_auto = 1;
        tick(20);
        chk(started == 0, "R3 autostart waits for NULL", started, 0);
        pulse(EV_NULL);
        tick(1);
        chk(started == 1, "R3 autostart on NULL", started, 1);
        tick(1);
        chk(connecting == 1 && tx_mode == 2'd2, "R5 connecting sends FCT", tx_mode, 2);
        link_auto = 0;
    endtask

    task automatic t_start_timeout();
        go_ready();
        link_start = 1;
        tick(1);
        link_start = 0;
        tick(TO_CYC - 1);
        chk(started == 1, "R4 still started before timeout", started, 1);
        tick(1);
        chk(!started && !rx_enable, "R4 timeout resets", rx_enable, 0);
        chk(err_seen == 0, "R4 no error flag", err_seen, 0);
    endtask

    task automatic t_fct_req();
        connect();
        chk(fct_req == 0, "R11 no FCT with room 0", fct_req, 0);
        rx_room = 6'd8;
        tick(1);
        chk(fct_req == 1, "R11 FCT with room 8", fct_req, 1);
        rx_room = 6'd15;
        pulse(EV_ACK);
        chk(fct_req == 0, "R11 room 15 under credit 8 plus 8", fct_req, 0);
        rx_room = 6'd16;
        tick(1);
        chk(fct_req == 1, "R11 room 16 covers credit 8 plus 8", fct_req, 1);
        pulse(EV_FCT);
        chk(running && tx_ready && tx_mode == 2'd3, "R6 FCT enters running", running, 1);
        rx_room = 6'd0;
        for (int i = 0; i < 8; i++) pulse(EV_CHAR);
        chk(running && err_seen == 0, "R12 eight chars within credit", running, 1);
        pulse(EV_CHAR);
        chk(err_cred == 1 && running == 0, "R12 char beyond credit", err_cred, 1);
        tick(1);
        chk(err_cred == 0, "R8 error flag lasts one cycle", err_cred, 0);
    endtask

    task automatic t_tx_credit();
        to_run();
        tx_write = 1;
        tick(7);
        chk(tx_ready == 1, "R9 credit left after 7 writes", tx_ready, 1);
        tick(1);
        chk(tx_ready == 0, "R9 credit used after 8 writes", tx_ready, 0);
        tx_write = 0;
        pulse(EV_FCT);
        chk(tx_ready == 1, "R9 FCT restores credit", tx_ready, 1);
        for (int i = 0; i < 6; i++) pulse(EV_FCT);
        chk(running && err_seen == 0, "R10 credit 56 allowed", running, 1);
        pulse(EV_FCT);
        chk(err_cred == 1 && running == 0, "R10 credit above 56", err_cred, 1);
    endtask

    task automatic t_run_errors();
        for (int i = 0; i < 3; i++) begin
            to_run();
            pulse(EV_PAR + i);
            chk((i == 0 ? err_par : (i == 1 ? err_esc : err_disc)) == 1,
                "R8 matching flag", i, 1);
            chk(int'(err_par) + int'(err_esc) + int'(err_disc) + int'(err_cred) == 1,
                "R8 only one flag", int'(err_par) + int'(err_esc) + int'(err_disc), 1);
            chk(running == 0 && rx_enable == 0, "R8 link falls to reset", running, 0);
            tick(1);
            chk(!err_par && !err_esc && !err_disc, "R8 flag one cycle", err_par, 0);
        end
    endtask

    task automatic t_bad_char();
        connect();
        pulse(EV_CHAR);
        chk(!connecting && !rx_enable && err_seen == 0, "R7 char in connecting", connecting, 0);
        go_ready();
        link_start = 1;
        tick(1);
        link_start = 0;
        pulse(EV_TIME);
        chk(!started && !rx_enable && err_seen == 0, "R7 time code in started", started, 0);
    endtask

    task automatic t_conn_timeout();
        connect();
        tick(TO_CYC - 1);
        chk(connecting == 1, "R6 connecting before timeout", connecting, 1);
        tick(1);
        chk(!connecting && !rx_enable && err_seen == 0, "R6 connecting timeout", connecting, 0);
    endtask

    task automatic t_disable();
        to_run();
        link_dis = 1;
        tick(1);
        chk(running == 0, "R13 disable drops running", running, 1'b0);
        tick(1);
        chk(err_seen == 0, "R13 no error on disable", err_seen, 0);
        go_ready();
        link_dis = 1; link_start = 1;
        tick(5);
        chk(started == 0, "R13 disable blocks start", started, 0);
        link_dis = 0; link_start = 0;
    endtask

    initial begin
        t_reset_timing();
        t_autostart();
        t_start_timeout();
        t_fct_req();
        t_tx_credit();
        t_run_errors();
        t_bad_char();
        t_conn_timeout();
        t_disable();
        chk(onehot_bad == 0, "R14 one state flag at a time", onehot_bad, 0);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual 1 expected 0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule